// File: doc/BRIEF.md
# Converter Register and Bus Interface

This block is the bus-facing half of an analog-to-digital converter peripheral. It answers a 32-word window on a 16-bit, word-addressed slave bus and holds the configuration, test and conversion control registers, a status register, a read-only view of a digital input port, and eight stored conversion results. Each result can be read through three banks of eight words. The right-justified bank, the left-justified bank and the signed bank all read the same stored value, each in its own format.

The analog side appears as a small handshake. The block pulses a start strobe for one channel at a time, reports an abort strobe, and gates the converter's clock enable. The converter returns a one-cycle done pulse with a 10-bit result. Software writes one control word that names a first channel and a count. The block then steps through that many channels, with wrap-around, and files each result in a slot numbered by its place in the sequence. A write to a conversion control register, or the setting of the stop bit, cuts a running sequence short. The registers stay usable while the converter is stopped.

Top module: `adc_regif`

## Requirements
- R1: A strobe that hits the window is acknowledged by a one-cycle `bus_ack` on the clock after the strobe is sampled, with read data valid in that cycle. A strobe whose address bits 23:6 differ from the base never gets an acknowledge. The word offset is address bits 5:1.
- R2: After reset, `bus_ack`, `bus_rdata`, `cnv_start` and `cnv_abort` are low, `cnv_clk_en` is high, and every register and result word reads zero.
- R3: Offsets 8–15, 16–23 and 24–31 read result slot (offset mod 8). The first bank gives the result in bits 9:0, the second gives it in bits 15:6, and the third gives it in bits 15:6 with result bit 9 inverted. Unused bits read zero.
- R4: A write to offset 5 (bits 2:0 first channel, bits 5:3 count minus one) with stop clear starts a sequence. `cnv_start` pulses on the following clock with `cnv_chan` equal to the first channel. Each accepted done stores `cnv_result` in the current slot and then starts the next channel (modulo 8) in the next slot. After the last slot, busy clears and complete sets. Offset 5 reads back bits 5:0.
- R5: Offset 6 is status: bit 15 complete, bit 14 busy, bits 2:0 current slot, other bits zero. Writes to it change nothing.
- R6: A write to offset 4 or 5 while busy pulses `cnv_abort` on the next clock, clears busy, leaves complete clear and leaves all stored results unchanged. A write to offset 5 then starts a fresh sequence.
- R7: Configuration bit 7 is the stop bit. While it is set, `cnv_clk_en` is low. Setting it while busy aborts as in R6. A write to offset 5 in stop starts nothing.
- R8: Registers stay writable and readable in stop. Configuration (offset 0) keeps bits 7:0, test (offset 1) keeps 16 bits, and offset 4 keeps bits 7:0. Unkept bits read zero.
- R9: Offsets 3 and 7 read zero and ignore writes, but they are acknowledged.
- R10: A done pulse while not busy, or in the same cycle as an abort, stores nothing.
- R11: Offset 2 returns `port_in`, zero-extended and sampled at the strobe edge. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe, held until acknowledge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Access termination |
| port_in | input | 8 | Digital input port |
| cnv_clk_en | output | 1 | Converter clock enable |
| cnv_start | output | 1 | Start one conversion |
| cnv_abort | output | 1 | Drop the conversion in flight |
| cnv_chan | output | 3 | Channel of the conversion being started |
| cnv_done | input | 1 | Conversion finished |
| cnv_result | input | 10 | Conversion value, valid with done |

## Verification
The hardest case to reach is an abort that lands while a conversion is really in flight, with older results already in storage that a faulty design could overwrite. The bench model of the converter takes a latency that the stimulus can set. Before each abort, a sequence is started with a latency long enough that the control write, or the stop write, arrives partway through the wait. The model drops its pending done when it sees the abort strobe. The bench then reads all three banks to confirm that the earlier results survived. A done pulse with no conversion running is injected on its own, with the model's automatic replies switched off.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int RES_W   = 10;
  localparam int DATA_W  = 16;
  localparam int SLOT_N  = 8;
  localparam int SLOT_W  = $clog2(SLOT_N);
  localparam int OFF_W   = 5;
  localparam int CFG_W   = 8;
  localparam int CTL0_W  = 8;
  localparam int CTL1_W  = 2 * SLOT_W;
  localparam int STOP_BIT = 7;
  localparam int STAT_DONE_BIT = 15;
  localparam int STAT_BUSY_BIT = 14;
  localparam int LJ_SHIFT = DATA_W - RES_W;

  typedef enum logic [2:0] {
    K_CFG, K_TEST, K_PORT, K_CTL0, K_CTL1, K_STAT, K_RSV, K_RES
  } reg_kind_e;

  typedef enum logic [1:0] {
    F_NONE, F_RIGHT, F_LEFT_U, F_LEFT_S
  } res_fmt_e;

  function automatic logic [DATA_W-1:0] fmt_right(input logic [RES_W-1:0] r);
    return DATA_W'(r);
  endfunction

  function automatic logic [DATA_W-1:0] fmt_left(input logic [RES_W-1:0] r);
    return {r, {LJ_SHIFT{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] fmt_signed(input logic [RES_W-1:0] r);
    return {~r[RES_W-1], r[RES_W-2:0], {LJ_SHIFT{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] fmt_apply(input res_fmt_e f,
                                                  input logic [RES_W-1:0] r);
    case (f)
      F_RIGHT:  return fmt_right(r);
      F_LEFT_U: return fmt_left(r);
      F_LEFT_S: return fmt_signed(r);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/adc_regif_decode.sv
module adc_regif_decode
  import adc_regif_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hFFF700
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output reg_kind_e         kind,
  output res_fmt_e          fmt,
  output logic [SLOT_W-1:0] slot
);
  localparam int TAG_LSB = OFF_W + 1;

  logic [OFF_W-1:0] off;

  assign win_hit = (addr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);
  assign off     = addr[OFF_W:1];
  assign fmt     = res_fmt_e'(off[OFF_W-1:SLOT_W]);
  assign slot    = off[SLOT_W-1:0];

  always_comb begin
    case (off)
      5'd0:    kind = K_CFG;
      5'd1:    kind = K_TEST;
      5'd2:    kind = K_PORT;
      5'd4:    kind = K_CTL0;
      5'd5:    kind = K_CTL1;
      5'd6:    kind = K_STAT;
      5'd3,
      5'd7:    kind = K_RSV;
      default: kind = K_RES;
    endcase
  end
endmodule

// File: rtl/adc_regif_seq.sv
module adc_regif_seq
  import adc_regif_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ctl0,
  input  logic                    wr_ctl1,
  input  logic                    stop_q,
  input  logic                    stop_set,
  input  logic [SLOT_W-1:0]       first_chan,
  input  logic [SLOT_W-1:0]       len_m1,
  input  logic                    cnv_done,
  input  logic [RES_W-1:0]        cnv_result,
  output logic                    cnv_start,
  output logic                    cnv_abort,
  output logic [SLOT_W-1:0]       cnv_chan,
  output logic                    busy,
  output logic                    complete,
  output logic [SLOT_W-1:0]       cur_slot,
  output logic [SLOT_N*RES_W-1:0] res_flat,
  output logic                    launch_evt,
  output logic                    abort_evt,
  output logic                    done_accept
);
  logic [SLOT_W-1:0] len_q;
  logic              last_slot;

  assign abort_evt   = busy & (wr_ctl0 | wr_ctl1 | stop_set);
  assign launch_evt  = wr_ctl1 & ~stop_q;
  assign done_accept = busy & cnv_done & ~abort_evt;
  assign last_slot   = (cur_slot == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      complete  <= 1'b0;
      cur_slot  <= '0;
      len_q     <= '0;
      cnv_chan  <= '0;
      cnv_start <= 1'b0;
      cnv_abort <= 1'b0;
    end else begin
      cnv_abort <= abort_evt;
      cnv_start <= 1'b0;
      if (wr_ctl1) complete <= 1'b0;
      if (launch_evt) begin
        busy      <= 1'b1;
        cur_slot  <= '0;
        len_q     <= len_m1;
        cnv_chan  <= first_chan;
        cnv_start <= 1'b1;
      end else if (abort_evt) begin
        busy <= 1'b0;
      end else if (done_accept) begin
        if (last_slot) begin
          busy     <= 1'b0;
          complete <= 1'b1;
        end else begin
          cur_slot  <= cur_slot + 1'b1;
          cnv_chan  <= cnv_chan + 1'b1;
          cnv_start <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    logic [RES_W-1:0] held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        held <= '0;
      else if (done_accept && cur_slot == SLOT_W'(g))
        held <= cnv_result;
    end
    assign res_flat[g*RES_W +: RES_W] = held;
  end
endmodule

// File: rtl/adc_regif_rdmux.sv
module adc_regif_rdmux
  import adc_regif_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  reg_kind_e               kind,
  input  res_fmt_e                fmt,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [CFG_W-1:0]        cfg_q,
  input  logic [DATA_W-1:0]       test_q,
  input  logic [PORT_W-1:0]       port_in,
  input  logic [CTL0_W-1:0]       ctl0_q,
  input  logic [CTL1_W-1:0]       ctl1_q,
  input  logic                    busy,
  input  logic                    complete,
  input  logic [SLOT_W-1:0]       cur_slot,
  input  logic [SLOT_N*RES_W-1:0] res_flat,
  output logic [DATA_W-1:0]       rd_value
);
  logic [RES_W-1:0]  picked;
  logic [DATA_W-1:0] stat_word;

  assign picked = res_flat[slot*RES_W +: RES_W];

  always_comb begin
    stat_word = '0;
    stat_word[STAT_DONE_BIT]  = complete;
    stat_word[STAT_BUSY_BIT]  = busy;
    stat_word[SLOT_W-1:0]     = cur_slot;
  end

  always_comb begin
    case (kind)
      K_CFG:   rd_value = DATA_W'(cfg_q);
      K_TEST:  rd_value = test_q;
      K_PORT:  rd_value = DATA_W'(port_in);
      K_CTL0:  rd_value = DATA_W'(ctl0_q);
      K_CTL1:  rd_value = DATA_W'(ctl1_q);
      K_STAT:  rd_value = stat_word;
      K_RES:   rd_value = fmt_apply(fmt, picked);
      default: rd_value = '0;
    endcase
  end
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hFFF700,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ack,
  input  logic [PORT_W-1:0] port_in,
  output logic              cnv_clk_en,
  output logic              cnv_start,
  output logic              cnv_abort,
  output logic [2:0]        cnv_chan,
  input  logic              cnv_done,
  input  logic [9:0]        cnv_result
);
  logic                    win_hit;
  reg_kind_e               kind;
  res_fmt_e                fmt;
  logic [SLOT_W-1:0]       slot;
  logic                    acc, wr_acc;
  logic                    wr_cfg, wr_test, wr_ctl0, wr_ctl1;
  logic                    stop_q, stop_set;
  logic [CFG_W-1:0]        cfg_q;
  logic [DATA_W-1:0]       test_q;
  logic [CTL0_W-1:0]       ctl0_q;
  logic [CTL1_W-1:0]       ctl1_q;
  logic                    busy, complete;
  logic [SLOT_W-1:0]       cur_slot;
  logic [SLOT_N*RES_W-1:0] res_flat;
  logic                    launch_evt, abort_evt, done_accept;
  logic [DATA_W-1:0]       rd_value;

  adc_regif_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .win_hit(win_hit), .kind(kind), .fmt(fmt), .slot(slot)
  );

  assign acc      = bus_sel & win_hit & ~bus_ack;
  assign wr_acc   = acc & bus_wr;
  assign wr_cfg   = wr_acc & (kind == K_CFG);
  assign wr_test  = wr_acc & (kind == K_TEST);
  assign wr_ctl0  = wr_acc & (kind == K_CTL0);
  assign wr_ctl1  = wr_acc & (kind == K_CTL1);
  assign stop_q   = cfg_q[STOP_BIT];
  assign stop_set = wr_cfg & bus_wdata[STOP_BIT] & ~stop_q;
  assign cnv_clk_en = ~stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      test_q <= '0;
      ctl0_q <= '0;
      ctl1_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= bus_wdata[CFG_W-1:0];
      if (wr_test) test_q <= bus_wdata;
      if (wr_ctl0) ctl0_q <= bus_wdata[CTL0_W-1:0];
      if (wr_ctl1) ctl1_q <= bus_wdata[CTL1_W-1:0];
    end
  end

  adc_regif_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl0(wr_ctl0), .wr_ctl1(wr_ctl1),
    .stop_q(stop_q), .stop_set(stop_set),
    .first_chan(bus_wdata[SLOT_W-1:0]),
    .len_m1(bus_wdata[CTL1_W-1:SLOT_W]),
    .cnv_done(cnv_done), .cnv_result(cnv_result),
    .cnv_start(cnv_start), .cnv_abort(cnv_abort), .cnv_chan(cnv_chan),
    .busy(busy), .complete(complete), .cur_slot(cur_slot),
    .res_flat(res_flat),
    .launch_evt(launch_evt), .abort_evt(abort_evt), .done_accept(done_accept)
  );

  adc_regif_rdmux #(.PORT_W(PORT_W)) u_rd (
    .kind(kind), .fmt(fmt), .slot(slot),
    .cfg_q(cfg_q), .test_q(test_q), .port_in(port_in),
    .ctl0_q(ctl0_q), .ctl1_q(ctl1_q),
    .busy(busy), .complete(complete), .cur_slot(cur_slot),
    .res_flat(res_flat), .rd_value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= acc;
      bus_rdata <= (acc && !bus_wr) ? rd_value : '0;
    end
  end
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_ack,
  input logic       win_hit,
  input logic       acc,
  input logic       busy,
  input logic       complete,
  input logic       stop_q,
  input logic       stop_set,
  input logic       abort_evt,
  input logic       launch_evt,
  input logic       cnv_start,
  input logic       cnv_abort,
  input logic       cnv_done,
  input logic [79:0] res_flat
);
  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> bus_ack);

  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_no_ack_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !win_hit) |=> !bus_ack);

  assert_start_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> busy);

  assert_abort_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !launch_evt) |=> (!busy && !complete && cnv_abort));

  assert_abort_keeps_results_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> $stable(res_flat));

  assert_stop_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_set && busy) |=> (cnv_abort && !busy));

  assert_no_start_in_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && $past(stop_q)) |-> !cnv_start);

  assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && !busy) |=> $stable(res_flat));
endmodule

bind adc_regif adc_regif_chk u_chk (.*);

// File: tb/adc_regif_bench.sv
module adc_regif_bench;
  localparam logic [23:0] BASE = 24'hFFF700;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  port_in = '0;
  logic        cnv_clk_en, cnv_start, cnv_abort;
  logic [2:0]  cnv_chan;
  logic        cnv_done = 1'b0;
  logic [9:0]  cnv_result = '0;

  always #2 clk = ~clk;

  adc_regif u_adc_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .port_in(port_in), .cnv_clk_en(cnv_clk_en),
    .cnv_start(cnv_start), .cnv_abort(cnv_abort), .cnv_chan(cnv_chan),
    .cnv_done(cnv_done), .cnv_result(cnv_result)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard queues: one entry per bus access
  bit          isrd_q[$];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (bus_ack) begin
      if (isrd_q.size() == 0) begin
        check(0, "R1 unexpected ack", 1, 0);
      end else begin
        bit rd; logic [15:0] e; string t;
        rd = isrd_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rd) check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic bus_access(bit wr, int off, logic [15:0] d, logic [15:0] e, string t);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = BASE + 24'(off * 2); bus_wdata = d;
    isrd_q.push_back(!wr); exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    check(bus_ack, "R1 ack after strobe", bus_ack, 1);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
    check(!bus_ack, "R1 ack one cycle", bus_ack, 0);
  endtask

  task automatic bus_write(int off, logic [15:0] d);
    bus_access(1, off, d, 16'h0, "");
  endtask

  task automatic bus_read(int off, logic [15:0] e, string t);
    bus_access(0, off, 16'h0, e, t);
  endtask

  // converter model
  int  eng_lat = 4;
  int  eng_seed = 0;
  bit  eng_on = 1;
  bit  inj_req = 0;
  logic [9:0] inj_val = '0;
  int  start_cnt = 0, abort_cnt = 0;

  function automatic logic [9:0] res_of(int ch, int seed);
    return 10'((ch * 137 + seed) % 1024);
  endfunction

  initial begin
    bit pend = 0; int cnt = 0; int ch = 0;
    forever begin
      @(negedge clk);
      cnv_done = 0;
      if (cnv_abort) begin abort_cnt++; pend = 0; end
      if (inj_req) begin
        cnv_done = 1; cnv_result = inj_val; inj_req = 0;
      end else if (cnv_start) begin
        start_cnt++; pend = 1; cnt = eng_lat; ch = int'(cnv_chan);
      end else if (pend && eng_on) begin
        if (cnt == 0) begin
          cnv_done = 1; cnv_result = res_of(ch, eng_seed); pend = 0;
        end else cnt--;
      end
    end
  end

  logic [9:0] model[8];

  task automatic check_banks(string t);
    for (int s = 0; s < 8; s++) begin
      bus_read(8 + s,  {6'b0, model[s]}, {"R3 right ", t});
      bus_read(16 + s, {model[s], 6'b0}, {"R3 left ", t});
      bus_read(24 + s, {~model[s][9], model[s][8:0], 6'b0}, {"R3 signed ", t});
    end
  endtask

  task automatic run_seq(int first, int n, int seed, int lat);
    eng_seed = seed; eng_lat = lat;
    bus_write(5, 16'(((n - 1) << 3) | first));
    repeat ((lat + 4) * n + 6) @(negedge clk);
    for (int i = 0; i < n; i++) model[i] = res_of((first + i) % 8, seed);
  endtask

  initial begin
    int ab, st;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    check(!bus_ack && bus_rdata == 0, "R2 bus idle", {bus_ack, bus_rdata}, 0);
    check(cnv_clk_en && !cnv_start && !cnv_abort, "R2 converter pins",
          {cnv_clk_en, cnv_start, cnv_abort}, 3'b100);
    bus_read(0, 16'h0000, "R2 cfg");
    bus_read(6, 16'h0000, "R2 status");
    check_banks("R2 reset");

    // R1 outside window
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 24'hFFF740;
    repeat (3) begin @(negedge clk); check(!bus_ack, "R1 miss no ack", bus_ack, 0); end
    bus_sel = 0;

    // R11 port
    port_in = 8'h5A; bus_read(2, 16'h005A, "R11 port");
    port_in = 8'hC3; bus_write(2, 16'hFFFF); bus_read(2, 16'h00C3, "R11 port write ignored");

    // R4 sequence with wrap, R3 formats
    st = start_cnt;
    run_seq(6, 4, 16'h1F0, 3);
    check(start_cnt == st + 4, "R4 start count", start_cnt - st, 4);
    bus_read(6, 16'h8003, "R5 status complete");
    bus_read(5, 16'h001E, "R4 ctl1 readback");
    check_banks("R4 seq1");
    run_seq(0, 8, 16'h055, 2);
    bus_read(6, 16'h8007, "R5 status full");
    check_banks("R4 seq2");
    bus_write(6, 16'h0000);
    bus_read(6, 16'h8007, "R5 status write ignored");

    // R6 abort by control 0
    eng_lat = 60; eng_seed = 16'h2A9; ab = abort_cnt;
    bus_write(5, 16'h0038);
    repeat (5) @(negedge clk);
    bus_read(6, 16'h4000, "R5 status busy");
    bus_write(4, 16'h003C);
    repeat (3) @(negedge clk);
    check(abort_cnt == ab + 1, "R6 abort pulse", abort_cnt - ab, 1);
    bus_read(6, 16'h0000, "R6 status after abort");
    bus_read(4, 16'h003C, "R8 ctl0 readback");
    repeat (80) @(negedge clk);
    check_banks("R6 kept");

    // R6 restart through control 1
    eng_lat = 60; eng_seed = 16'h111; ab = abort_cnt;
    bus_write(5, 16'h0012);
    repeat (5) @(negedge clk);
    eng_lat = 3; eng_seed = 16'h3C7;
    bus_write(5, 16'h000D);
    repeat (30) @(negedge clk);
    check(abort_cnt == ab + 1, "R6 restart abort", abort_cnt - ab, 1);
    model[0] = res_of(5, 16'h3C7); model[1] = res_of(6, 16'h3C7);
    bus_read(6, 16'h8001, "R6 restart status");
    check_banks("R6 restart");

    // R7 stop
    eng_lat = 60; eng_seed = 16'h0AA; ab = abort_cnt;
    bus_write(5, 16'h0018);
    repeat (5) @(negedge clk);
    bus_write(0, 16'h0080);
    check(!cnv_clk_en, "R7 clock gated", cnv_clk_en, 0);
    check(abort_cnt == ab + 1, "R7 stop aborts", abort_cnt - ab, 1);
    bus_read(6, 16'h0000, "R7 status after stop");
    st = start_cnt;
    bus_write(5, 16'h0000);
    repeat (10) @(negedge clk);
    check(start_cnt == st, "R7 no start in stop", start_cnt - st, 0);
    bus_read(6, 16'h0000, "R7 idle in stop");
    bus_read(0, 16'h0080, "R8 cfg in stop");
    bus_write(1, 16'hA5C3); bus_read(1, 16'hA5C3, "R8 test in stop");
    bus_write(4, 16'hFFFF); bus_read(4, 16'h00FF, "R8 ctl0 width");
    bus_write(0, 16'hFF00); bus_read(0, 16'h0000, "R8 cfg width");
    check(cnv_clk_en, "R7 clock back", cnv_clk_en, 1);
    repeat (80) @(negedge clk);
    check_banks("R7 kept");

    // R9 reserved
    bus_write(3, 16'hFFFF); bus_write(7, 16'h1234);
    bus_read(3, 16'h0000, "R9 offset 3");
    bus_read(7, 16'h0000, "R9 offset 7");

    // R10 idle done
    eng_on = 0;
    @(negedge clk); inj_val = 10'h3FF; inj_req = 1;
    repeat (4) @(negedge clk);
    eng_on = 1;
    bus_read(6, 16'h0000, "R10 status");
    check_banks("R10 idle done");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule